// File: doc/BRIEF.md
# Hart Step Outcome Sequencer

This block decides, once per qualified step, what a single hardware thread does with the instruction in front of it. It can take a pending interrupt, report a fetch fault, retire the instruction, raise a trap or illegal-instruction request, or park the thread in a wait state after a wait-for-interrupt. It also produces the program-counter increment for a retired instruction and keeps a retired-instruction counter. Decoding, execution and trap vectoring happen elsewhere. The block sees only the result code that execution returns.

While parked, the block keeps the bits and length of the instruction that caused the wait. When the thread leaves the wait state, that instruction is retired or reported as illegal, and the interrupt that woke it is taken on a later step. The retire counter can be loaded by an explicit write. A write in a step suppresses that step's increment.

Top module: `hart_step_ctrl`

## Requirements
- R1: After reset the thread is active (`waiting`=0), `retireCount` is zero, and with `stepValid` low every request output is 0 and `pcInc` is 0.
- R2: With `stepValid` low, `stepped`, `trapReq` and `illegalReq` are 0, `pcInc` is 0, and neither the wait state nor the counter changes.
- R3: In the active state the order of priority is: pending interrupt first, then fetch fault, then execution. Either of the first two gives `trapReq`=1 and `stepped`=1, with no retirement and `pcInc`=0.
- R4: In the active state a successful result (`execResult`=0) retires the instruction with `stepped`=1. `pcInc` is 4 for a 32-bit instruction, and 2 for a 16-bit one (`instrIsCompressed`=1) when `rvcEnable`=1.
- R5: In the active state, a 16-bit instruction with `rvcEnable`=0 gives `illegalReq`=1 whatever the value of `execResult`. `illegalBits` then holds the low 16 instruction bits zero-extended, and nothing retires.
- R6: `execResult`=1 gives `trapReq`=1. `execResult`=2 gives `illegalReq`=1 with the instruction bits on `illegalBits`. Both report `stepped`=1 with `pcInc`=0.
- R7: `execResult`=3 (wait-for-interrupt) with `wfiAsNop`=0 moves the thread to the waiting state. That step has `stepped`=0 and `pcInc`=0, and it does not count.
- R8: `execResult`=3 with `wfiAsNop`=1 behaves exactly like a successful retirement.
- R9: In the waiting state, a pending interrupt returns the thread to active and retires the parked instruction. `pcInc` is the parked instruction's length. `trapReq` is 0 on that step.
- R10: In the waiting state with no interrupt pending, `forceExit` returns the thread to active. The parked instruction retires if `curPriv`=2'b11 or `timeoutWait`=0. Otherwise the step gives `illegalReq`=1 with the parked bits on `illegalBits`.
- R11: In the waiting state with neither an interrupt nor a forced exit, the thread stays waiting with `stepped`=0. `fetchFault`, `execResult` and the instruction inputs are ignored, and `retireCount` does not change.
- R12: On a step that retires, `retireCount` increments by one if `incEnable`=1 and `counterWrite`=0. On a step with `counterWrite`=1, the counter takes `counterWData` and does not increment. `incEnable`=0 suppresses the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stepValid | input | 1 | Qualifies this cycle as one step |
| intPending | input | 1 | An enabled interrupt is pending |
| fetchFault | input | 1 | The fetch of this step faulted |
| instrIsCompressed | input | 1 | The fetched instruction is 16 bits |
| instrBits | input | 32 | Fetched instruction bits |
| rvcEnable | input | 1 | The compressed extension is enabled |
| curPriv | input | 2 | Current privilege, 2'b11 is machine |
| timeoutWait | input | 1 | Timeout-wait control bit |
| forceExit | input | 1 | Request to leave the wait state |
| wfiAsNop | input | 1 | Treat wait-for-interrupt as a no-op |
| execResult | input | 2 | 0 ok, 1 trap, 2 illegal, 3 wait-for-interrupt |
| incEnable | input | 1 | Counter increment enable at the start of the step |
| counterWrite | input | 1 | This step writes the retire counter |
| counterWData | input | CNT_W | Value written to the counter |
| trapReq | output | 1 | Interrupt, fetch fault or execution trap request |
| illegalReq | output | 1 | Illegal-instruction request |
| illegalBits | output | 32 | Offending instruction bits when `illegalReq` is 1 |
| pcInc | output | 3 | PC increment of a retiring step, otherwise 0 |
| stepped | output | 1 | The thread is active at the end of the step |
| waiting | output | 1 | The thread is in the waiting state |
| retireCount | output | CNT_W | Retired-instruction counter |

## Verification
Two events can fall in the same step: an explicit counter write and a retirement. The bench drives `counterWrite` on steps that retire and expects the written value, not an increment, on the next cycle. A wake-up interrupt and a forced exit can also arrive together while the thread is waiting. The bench expects the interrupt to win, with a plain retirement even at a lower privilege with `timeoutWait` set, and it expects no trap until the following step. A behavioural model in the bench judges every cycle of a directed sequence and of a long random run, in which parked waits are frequent.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TRAP    = 2'd1,
    RES_ILLEGAL = 2'd2,
    RES_WFI     = 2'd3
  } exec_res_t;

  // strobes from control to datapath
  typedef struct packed {
    logic retire;      // instruction retires this step
    logic enterWait;   // park the current instruction
    logic fromWait;    // step resolves a parked instruction
    logic illegal;     // illegal-instruction outcome
    logic compressed;  // current instruction is 16 bits
  } step_strobe_t;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;
endpackage

// File: rtl/hsc_control.sv
module hsc_control
  import hsc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         stepValid,
  input  logic         intPending,
  input  logic         fetchFault,
  input  logic         instrIsCompressed,
  input  logic         rvcEnable,
  input  logic [1:0]   curPriv,
  input  logic         timeoutWait,
  input  logic         forceExit,
  input  logic         wfiAsNop,
  input  logic [1:0]   execResult,
  output step_strobe_t strobe,
  output logic         stepped,
  output logic         trapReq,
  output logic         waiting
);
  logic waitQ, waitD;
  exec_res_t res;

  assign res     = exec_res_t'(execResult);
  assign waiting = waitQ;

  always_comb begin
    strobe  = '0;
    stepped = 1'b0;
    trapReq = 1'b0;
    waitD   = waitQ;
    if (stepValid) begin
      if (waitQ) begin
        strobe.fromWait = 1'b1;
        if (intPending) begin
          waitD         = 1'b0;
          stepped       = 1'b1;
          strobe.retire = 1'b1;
        end else if (forceExit) begin
          waitD   = 1'b0;
          stepped = 1'b1;
          if (curPriv == PRIV_MACHINE || !timeoutWait) strobe.retire = 1'b1;
          else strobe.illegal = 1'b1;
        end
      end else begin
        strobe.compressed = instrIsCompressed;
        stepped           = 1'b1;
        if (intPending || fetchFault) begin
          trapReq = 1'b1;
        end else if (instrIsCompressed && !rvcEnable) begin
          strobe.illegal = 1'b1;
        end else begin
          unique case (res)
            RES_OK:      strobe.retire  = 1'b1;
            RES_TRAP:    trapReq        = 1'b1;
            RES_ILLEGAL: strobe.illegal = 1'b1;
            RES_WFI: begin
              if (wfiAsNop) begin
                strobe.retire = 1'b1;
              end else begin
                strobe.enterWait = 1'b1;
                stepped          = 1'b0;
                waitD            = 1'b1;
              end
            end
            default: trapReq = 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitQ <= 1'b0;
    else       waitQ <= waitD;
  end
endmodule

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int CNT_W   = 16,
  parameter int INC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               stepValid,
  input  step_strobe_t       strobe,
  input  logic [INSTR_W-1:0] instrBits,
  input  logic               incEnable,
  input  logic               counterWrite,
  input  logic [CNT_W-1:0]   counterWData,
  output logic               illegalReq,
  output logic [INSTR_W-1:0] illegalBits,
  output logic [INC_W-1:0]   pcInc,
  output logic [CNT_W-1:0]   retireCount
);
  localparam int HALF_W = INSTR_W / 2;
  localparam logic [INC_W-1:0] INC_HALF = INC_W'(INSTR_W / 16);
  localparam logic [INC_W-1:0] INC_FULL = INC_W'(INSTR_W / 8);

  logic [INSTR_W-1:0] parkedBits, instrView;
  logic               parkedComp, lenComp;
  logic [CNT_W-1:0]   countQ;

  assign instrView   = strobe.compressed ? {{HALF_W{1'b0}}, instrBits[HALF_W-1:0]} : instrBits;
  assign lenComp     = strobe.fromWait ? parkedComp : strobe.compressed;
  assign illegalReq  = strobe.illegal;
  assign illegalBits = strobe.illegal ? (strobe.fromWait ? parkedBits : instrView) : '0;
  assign pcInc       = strobe.retire ? (lenComp ? INC_HALF : INC_FULL) : '0;
  assign retireCount = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parkedBits <= '0;
      parkedComp <= 1'b0;
    end else if (strobe.enterWait) begin
      parkedBits <= instrView;
      parkedComp <= strobe.compressed;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           countQ <= '0;
    else if (stepValid && counterWrite)  countQ <= counterWData;
    else if (strobe.retire && incEnable) countQ <= countQ + 1'b1;
  end
endmodule

// File: rtl/hart_step_ctrl.sv
module hart_step_ctrl
  import hsc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepValid,
  input  logic             intPending,
  input  logic             fetchFault,
  input  logic             instrIsCompressed,
  input  logic [31:0]      instrBits,
  input  logic             rvcEnable,
  input  logic [1:0]       curPriv,
  input  logic             timeoutWait,
  input  logic             forceExit,
  input  logic             wfiAsNop,
  input  logic [1:0]       execResult,
  input  logic             incEnable,
  input  logic             counterWrite,
  input  logic [CNT_W-1:0] counterWData,
  output logic             trapReq,
  output logic             illegalReq,
  output logic [31:0]      illegalBits,
  output logic [2:0]       pcInc,
  output logic             stepped,
  output logic             waiting,
  output logic [CNT_W-1:0] retireCount
);
  step_strobe_t strobe;

  hsc_control u_ctrl (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .intPending(intPending),
    .fetchFault(fetchFault), .instrIsCompressed(instrIsCompressed),
    .rvcEnable(rvcEnable), .curPriv(curPriv), .timeoutWait(timeoutWait),
    .forceExit(forceExit), .wfiAsNop(wfiAsNop), .execResult(execResult),
    .strobe(strobe), .stepped(stepped), .trapReq(trapReq), .waiting(waiting)
  );

  hsc_datapath #(.INSTR_W(32), .CNT_W(CNT_W), .INC_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .stepValid(stepValid), .strobe(strobe),
    .instrBits(instrBits), .incEnable(incEnable), .counterWrite(counterWrite),
    .counterWData(counterWData), .illegalReq(illegalReq),
    .illegalBits(illegalBits), .pcInc(pcInc), .retireCount(retireCount)
  );
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepValid,
  input logic             intPending,
  input logic             forceExit,
  input logic             incEnable,
  input logic             counterWrite,
  input logic             trapReq,
  input logic             illegalReq,
  input logic [2:0]       pcInc,
  input logic             stepped,
  input logic             waiting,
  input logic [CNT_W-1:0] retireCount
);
  // R2: an unqualified cycle produces no outcome
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |-> (!stepped && !trapReq && !illegalReq && pcInc == 3'd0));

  // R3, R6: one outcome per step, and a trap never advances the PC
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapReq, illegalReq, pcInc != 3'd0}));

  // R7: a step that reports stepped leaves the thread active
  p_stepped_active_r7: assert property (@(posedge clk) disable iff (!rstN)
    stepped |=> !waiting);

  // R9: waking from the wait state never takes the interrupt in the same step
  p_wake_no_trap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && stepValid) |-> !trapReq);

  // R11: an idle wait holds the state and the counter
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && stepValid && !intPending && !forceExit && !counterWrite)
      |=> (waiting && $stable(retireCount)));

  // R12: a counted retirement adds exactly one
  p_count_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && pcInc != 3'd0 && incEnable && !counterWrite)
      |=> retireCount == CNT_W'($past(retireCount) + 1'b1));
endmodule

bind hart_step_ctrl hsc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stepValid(stepValid), .intPending(intPending),
  .forceExit(forceExit), .incEnable(incEnable), .counterWrite(counterWrite),
  .trapReq(trapReq), .illegalReq(illegalReq), .pcInc(pcInc),
  .stepped(stepped), .waiting(waiting), .retireCount(retireCount)
);

// File: tb/hart_step_ctrl_tb.sv
module hart_step_ctrl_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stepValid = 0, intPending = 0, fetchFault = 0, instrIsCompressed = 0;
  logic [31:0] instrBits = '0;
  logic rvcEnable = 0, timeoutWait = 0, forceExit = 0, wfiAsNop = 0;
  logic [1:0] curPriv = 2'b11, execResult = 2'd0;
  logic incEnable = 0, counterWrite = 0;
  logic [CNT_W-1:0] counterWData = '0;
  logic trapReq, illegalReq, stepped, waiting;
  logic [31:0] illegalBits;
  logic [2:0] pcInc;
  logic [CNT_W-1:0] retireCount;

  int total = 0, bad = 0;

  // reference model state
  bit mWait = 0;
  bit mComp = 0;
  logic [31:0] mBits = '0;
  int unsigned mCount = 0;

  always #4 clk = ~clk;

  hart_step_ctrl #(.CNT_W(CNT_W)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // drive one cycle, compare against the model, advance the model
  task automatic step(input bit v, input bit ip, input bit ff, input bit cmp,
                      input logic [31:0] bits, input bit rvc, input logic [1:0] priv,
                      input bit tw, input bit fx, input bit nop, input logic [1:0] res,
                      input bit inc, input bit cw, input logic [CNT_W-1:0] wd);
    bit eSt, eTrap, eIll, eRet, goWait, leave;
    logic [31:0] eBits, view;
    logic [2:0] eInc;
    string tag;
    @(negedge clk);
    stepValid = v; intPending = ip; fetchFault = ff; instrIsCompressed = cmp;
    instrBits = bits; rvcEnable = rvc; curPriv = priv; timeoutWait = tw;
    forceExit = fx; wfiAsNop = nop; execResult = res; incEnable = inc;
    counterWrite = cw; counterWData = wd;
    #1;
    eSt = 0; eTrap = 0; eIll = 0; eRet = 0; eBits = '0; eInc = '0;
    goWait = 0; leave = 0;
    view = cmp ? {16'h0, bits[15:0]} : bits;
    if (!v) tag = "R2";
    else if (mWait) begin
      if (ip) begin tag = "R9"; leave = 1; eSt = 1; eRet = 1; end
      else if (fx) begin
        tag = "R10"; leave = 1; eSt = 1;
        if (priv == 2'b11 || !tw) eRet = 1;
        else begin eIll = 1; eBits = mBits; end
      end else tag = "R11";
      if (eRet) eInc = mComp ? 3'd2 : 3'd4;
    end else begin
      eSt = 1;
      if (ip || ff) begin tag = "R3"; eTrap = 1; end
      else if (cmp && !rvc) begin tag = "R5"; eIll = 1; eBits = view; end
      else if (res == 2'd0) begin tag = "R4"; eRet = 1; end
      else if (res == 2'd1) begin tag = "R6"; eTrap = 1; end
      else if (res == 2'd2) begin tag = "R6"; eIll = 1; eBits = view; end
      else if (nop) begin tag = "R8"; eRet = 1; end
      else begin tag = "R7"; eSt = 0; goWait = 1; end
      if (eRet) eInc = cmp ? 3'd2 : 3'd4;
    end
    check(stepped === eSt && trapReq === eTrap && illegalReq === eIll &&
          illegalBits === eBits && pcInc === eInc && waiting === mWait, tag,
          $sformatf("st/trap/ill/bits/inc/wait got %0b %0b %0b %h %0d %0b exp %0b %0b %0b %h %0d %0b",
                    stepped, trapReq, illegalReq, illegalBits, pcInc, waiting,
                    eSt, eTrap, eIll, eBits, eInc, mWait));
    check(retireCount === CNT_W'(mCount), "R12",
          $sformatf("count got %0d exp %0d", retireCount, CNT_W'(mCount)));
    if (v && cw) mCount = wd;
    else if (eRet && inc) mCount = (mCount + 1) % (1 << CNT_W);
    if (goWait) begin mWait = 1; mBits = view; mComp = cmp; end
    if (leave) mWait = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(waiting === 1'b0 && retireCount === '0 && stepped === 1'b0 &&
          trapReq === 1'b0 && illegalReq === 1'b0 && pcInc === 3'd0, "R1",
          $sformatf("wait %0b count %0d got, exp 0 0", waiting, retireCount));
    @(negedge clk); rstN = 1'b1;
    //   v ip ff cmp bits          rvc priv  tw fx nop res inc cw wd
    step(0, 1, 1, 0, 32'h11111111, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);   // R2
    step(1, 0, 0, 0, 32'h00000013, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);   // R4 32-bit
    step(1, 0, 0, 1, 32'hABCD0001, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);   // R4 16-bit
    step(1, 1, 1, 0, 32'h0, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);          // R3 int first
    step(1, 0, 1, 1, 32'h0, 0, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);          // R3 fault over R5
    step(1, 0, 0, 1, 32'hDEAD4501, 0, 2'b11, 0, 0, 0, 2'd3, 1, 0, 0);   // R5
    step(1, 0, 0, 0, 32'h12345678, 1, 2'b11, 0, 0, 0, 2'd1, 1, 0, 0);   // R6 trap
    step(1, 0, 0, 0, 32'hFFFF0000, 1, 2'b11, 0, 0, 0, 2'd2, 1, 0, 0);   // R6 illegal
    step(1, 0, 0, 0, 32'h10500073, 1, 2'b11, 0, 0, 1, 2'd3, 1, 0, 0);   // R8
    step(1, 0, 0, 0, 32'h10500073, 1, 2'b00, 1, 0, 0, 2'd3, 1, 0, 0);   // R7 enter wait
    step(1, 0, 1, 0, 32'h0, 1, 2'b00, 1, 0, 0, 2'd1, 1, 0, 0);          // R11 hold
    step(1, 0, 0, 0, 32'h0, 1, 2'b00, 1, 1, 0, 2'd0, 1, 0, 0);          // R10 illegal
    step(1, 0, 0, 0, 32'h10500073, 1, 2'b01, 1, 0, 0, 2'd3, 1, 0, 0);   // R7
    step(1, 0, 0, 0, 32'h0, 1, 2'b01, 0, 1, 0, 2'd0, 1, 0, 0);          // R10 retire tw=0
    step(1, 0, 0, 1, 32'h77778001, 1, 2'b00, 1, 0, 0, 2'd3, 1, 0, 0);   // R7 16-bit
    step(1, 1, 0, 0, 32'h0, 1, 2'b00, 1, 1, 0, 2'd0, 1, 0, 0);          // R9 wins over exit
    step(1, 1, 0, 0, 32'h0, 1, 2'b00, 1, 0, 0, 2'd0, 1, 0, 0);          // R3 int taken now
    step(1, 0, 0, 0, 32'h13, 1, 2'b11, 0, 0, 0, 2'd0, 1, 1, 16'h0100); // R12 write wins
    step(1, 0, 0, 0, 32'h13, 1, 2'b11, 0, 0, 0, 2'd0, 0, 0, 0);         // R12 inhibited
    step(1, 0, 0, 0, 32'h13, 1, 2'b11, 0, 0, 0, 2'd0, 1, 1, 16'hFFFF); // R12 wrap setup
    step(1, 0, 0, 0, 32'h13, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);         // R12 wrap
    step(0, 0, 0, 0, 32'h0, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);          // R12 observe
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[0] | r[1], r[2] & r[3] & r[4], r[5] & r[6] & r[7], r[8], $urandom,
           r[9] | r[10], r[12:11], r[13], r[14] & r[15], r[16] & r[17], r[19:18],
           r[20] | r[21], r[22] & r[23] & r[24], CNT_W'($urandom));
    end
    step(0, 0, 0, 0, 32'h0, 1, 2'b11, 0, 0, 0, 2'd0, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule